// File: doc/BRIEF.md
# Variable Block Size SAD Minimum Tracker

This block sits behind a 4x4 absolute-difference array in an integer motion search. For every candidate displacement of a 16x16 macroblock it accepts the sixteen 4x4 sub-block SADs in one cycle. From those sixteen values alone it builds the cost of every larger partition shape: 8x4, 4x8, 8x8, 16x8, 8x16 and 16x16. Together with the sixteen 4x4 costs this gives 41 partition costs per candidate. Pixels are never read a second time.

Each of the 41 partitions keeps its own running minimum and the displacement where that minimum was found. Candidates arrive in raster order over a 16x16 window, with displacements from -8 to +7 on each axis, so 256 candidates make up one macroblock. The displacement is derived inside the block from the position of the candidate in the scan. After the 256th accepted candidate, a one-cycle done strobe signals that all 41 results are final. The results then stay unchanged until the next macroblock starts.

Top module: `vbs_sad_merge`

## Requirements
- R1: While reset is low and after its release, every best SAD and every motion vector field reads zero and done is low.
- R2: Input `sub_sad` carries sub-block k in bits [12k+11:12k], where k = 4*row + col. Output slot k (0..15) holds the smallest SAD seen for sub-block k in the current macroblock, together with its displacement.
- R3: Slots 16..23 hold 8x4 minima. Slot 16+j, with j = 2*row + h, sums sub-blocks 4*row+2h and 4*row+2h+1. Slots 24..31 hold 4x8 minima. Slot 24+j, with j = 4*v + col, sums sub-blocks 8*v+col and 8*v+col+4.
- R4: Slots 32..35 hold the 8x8 quadrants, numbered q = 2*qrow + qcol. Slots 36 and 37 hold the top and bottom 16x8 halves. Slots 38 and 39 hold the left and right 8x16 halves. Slot 40 holds the full 16x16 block. Each slot is the minimum over candidates of the sum of the sub-blocks it covers.
- R5: The candidate at scan position n (0..255) has displacement x = (n mod 16) - 8 and y = (n div 16) - 8, each in 5-bit two's complement. Slot p holds x in `best_mv` bits [10p+4:10p] and y in bits [10p+9:10p+5]. Each best SAD occupies 16 bits at [16p+15:16p].
- R6: A candidate replaces a stored minimum only when its SAD is strictly smaller, so on a tie the earlier candidate in the scan is kept.
- R7: A candidate presented with `mb_start` high is scan position 0. It loads all 41 slots unconditionally, whatever the stored values, and it restarts the scan even in the middle of a macroblock.
- R8: `done` is high for exactly one cycle: the cycle after the clock edge that accepts the 256th candidate. In that cycle all 41 outputs show the final results.
- R9: Once a macroblock has completed, candidates without `mb_start` are ignored. Outputs do not change while `cand_valid` is low.
- R10: Cycles with `cand_valid` low do not advance the scan position, so gaps in the candidate stream do not change the results or the position of `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cand_valid | input | 1 | A candidate's sub-block SADs are present |
| mb_start | input | 1 | Marks the first candidate of a macroblock (qualified by cand_valid) |
| sub_sad | input | 192 | Sixteen 12-bit 4x4 SADs, sub-block k at bits [12k+11:12k] |
| best_sad | output | 656 | 41 best SADs, 16 bits each |
| best_mv | output | 410 | 41 displacements, 10 bits each (x low, y high) |
| done | output | 1 | One-cycle pulse: all results are final |

## Verification
Two functions can land in the same cycle. One is the completion pulse of a finished macroblock. The other is the unconditional load by the first candidate of the next macroblock. The bench provokes this by presenting the new macroblock's first candidate, with `mb_start`, in the very cycle that `done` is high. It judges the result in two steps: in that cycle all 41 outputs must still hold the old macroblock's results, and after the next edge they must hold the new candidate's values, with displacement (-8,-8), and `done` must be low. A second overlap, a restart in mid-scan whose SADs exceed the stored minima, checks that the load wins over the strict less-than compare.

// File: rtl/vbs_pkg.sv
// Package: partition counts and output slot offsets shared by the merger,
// its sub-modules and its checker. Counts follow from tiling a 16x16 block.
package vbs_pkg;
    localparam int NSUB     = 16;
    localparam int N_8X4    = 8;
    localparam int N_4X8    = 8;
    localparam int N_8X8    = 4;
    localparam int N_16X8   = 2;
    localparam int N_8X16   = 2;
    localparam int N_16X16  = 1;
    localparam int OFS_8X4  = NSUB;
    localparam int OFS_4X8  = OFS_8X4 + N_8X4;
    localparam int OFS_8X8  = OFS_4X8 + N_4X8;
    localparam int OFS_16X8 = OFS_8X8 + N_8X8;
    localparam int OFS_8X16 = OFS_16X8 + N_16X8;
    localparam int OFS_FULL = OFS_8X16 + N_8X16;
    localparam int NPART    = OFS_FULL + N_16X16;
endpackage

// File: rtl/vbs_sad_tree.sv
// Module: vbs_sad_tree
// Combinational adder tree. It widens the sixteen 4x4 SADs and sums them into
// all 41 partition costs, in the slot order defined in vbs_pkg.
// Assumes SAD_W is wide enough for sixteen SUB_W-bit terms.
module vbs_sad_tree
    import vbs_pkg::*;
#(
    parameter int SUB_W = 12,
    parameter int SAD_W = 16
) (
    input  logic [NSUB*SUB_W-1:0]  sub_in,
    output logic [NPART*SAD_W-1:0] part_out
);
    logic [SAD_W-1:0] s4  [NSUB];
    logic [SAD_W-1:0] s84 [N_8X4];
    logic [SAD_W-1:0] s48 [N_4X8];
    logic [SAD_W-1:0] s88 [N_8X8];

    // Widen each sub-block SAD and pass it through as a 4x4 slot.
    for (genvar k = 0; k < NSUB; k++) begin : g_sub
        assign s4[k] = SAD_W'(sub_in[k*SUB_W +: SUB_W]);
        assign part_out[k*SAD_W +: SAD_W] = s4[k];
    end

    // Horizontal pairs (8x4) and vertical pairs (4x8).
    for (genvar j = 0; j < N_8X4; j++) begin : g_pair
        localparam int HR = j / 2;
        localparam int HC = (j % 2) * 2;
        localparam int VR = (j / 4) * 2;
        localparam int VC = j % 4;
        assign s84[j] = s4[4*HR + HC] + s4[4*HR + HC + 1];
        assign s48[j] = s4[4*VR + VC] + s4[4*VR + VC + 4];
        assign part_out[(OFS_8X4 + j)*SAD_W +: SAD_W] = s84[j];
        assign part_out[(OFS_4X8 + j)*SAD_W +: SAD_W] = s48[j];
    end

    // Quadrants: two stacked 8x4 costs each.
    for (genvar q = 0; q < N_8X8; q++) begin : g_quad
        localparam int QR = q / 2;
        localparam int QC = q % 2;
        assign s88[q] = s84[4*QR + QC] + s84[4*QR + 2 + QC];
        assign part_out[(OFS_8X8 + q)*SAD_W +: SAD_W] = s88[q];
    end

    // Halves and the whole block from the quadrants.
    assign part_out[(OFS_16X8    )*SAD_W +: SAD_W] = s88[0] + s88[1];
    assign part_out[(OFS_16X8 + 1)*SAD_W +: SAD_W] = s88[2] + s88[3];
    assign part_out[(OFS_8X16    )*SAD_W +: SAD_W] = s88[0] + s88[2];
    assign part_out[(OFS_8X16 + 1)*SAD_W +: SAD_W] = s88[1] + s88[3];
    assign part_out[(OFS_FULL    )*SAD_W +: SAD_W] = s88[0] + s88[1] + s88[2] + s88[3];
endmodule

// File: rtl/vbs_scan_ctrl.sv
// Module: vbs_scan_ctrl
// Tracks the scan position of accepted candidates within a macroblock and
// raises done after the last one. Assumes mb_start arrives together with
// cand_valid on the first candidate. Candidates are ignored when no scan is active.
module vbs_scan_ctrl #(
    parameter int NCAND = 256,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cand_valid,
    input  logic             mb_start,
    output logic             take,
    output logic             load_all,
    output logic [IDX_W-1:0] cand_idx,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NCAND - 1);

    logic             active;
    logic [IDX_W-1:0] cnt;

    assign load_all = cand_valid & mb_start;
    assign take     = cand_valid & (mb_start | active);
    assign cand_idx = load_all ? '0 : cnt;

    // Advance the scan position and pulse done on the final candidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            done   <= 1'b0;
        end else begin
            done <= take && (cand_idx == LAST);
            if (take) begin
                if (cand_idx == LAST) begin
                    active <= 1'b0;
                    cnt    <= '0;
                end else begin
                    active <= 1'b1;
                    cnt    <= cand_idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/vbs_min_cell.sv
// Module: vbs_min_cell
// One partition's running minimum and its displacement. It loads on load_all
// and otherwise replaces the stored value only on a strictly smaller cost.
module vbs_min_cell #(
    parameter int SAD_W = 16,
    parameter int MVP_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             load_all,
    input  logic [SAD_W-1:0] sad_in,
    input  logic [MVP_W-1:0] mv_in,
    output logic [SAD_W-1:0] best_sad,
    output logic [MVP_W-1:0] best_mv
);
    logic better;
    assign better = take && (load_all || (sad_in < best_sad));

    // Hold the best cost and its displacement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_sad <= '0;
            best_mv  <= '0;
        end else if (better) begin
            best_sad <= sad_in;
            best_mv  <= mv_in;
        end
    end
endmodule

// File: rtl/vbs_sad_merge.sv
// Module: vbs_sad_merge (top)
// Builds all 41 partition costs for each candidate, derives the candidate's
// displacement from its raster position, and keeps one minimum per partition.
// Assumes SR_SIDE is a power of two and MV_W exceeds log2(SR_SIDE).
module vbs_sad_merge
    import vbs_pkg::*;
#(
    parameter int SUB_W   = 12,
    parameter int SAD_W   = 16,
    parameter int MV_W    = 5,
    parameter int SR_SIDE = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cand_valid,
    input  logic                       mb_start,
    input  logic [NSUB*SUB_W-1:0]      sub_sad,
    output logic [NPART*SAD_W-1:0]     best_sad,
    output logic [NPART*2*MV_W-1:0]    best_mv,
    output logic                       done
);
    localparam int NCAND  = SR_SIDE * SR_SIDE;
    localparam int HALF_W = $clog2(SR_SIDE);
    localparam int IDX_W  = 2 * HALF_W;
    localparam int MVP_W  = 2 * MV_W;

    logic                   take;
    logic                   load_all;
    logic [IDX_W-1:0]       cand_idx;
    logic [NPART*SAD_W-1:0] part_sad;
    logic [MV_W-1:0]        mv_x;
    logic [MV_W-1:0]        mv_y;
    logic [MVP_W-1:0]       mv_pack;

    vbs_sad_tree #(.SUB_W(SUB_W), .SAD_W(SAD_W)) u_tree (
        .sub_in   (sub_sad),
        .part_out (part_sad)
    );

    vbs_scan_ctrl #(.NCAND(NCAND), .IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand_valid (cand_valid),
        .mb_start   (mb_start),
        .take       (take),
        .load_all   (load_all),
        .cand_idx   (cand_idx),
        .done       (done)
    );

    // Displacement: column and row of the scan position, offset to centre.
    assign mv_x    = MV_W'(cand_idx[HALF_W-1:0])     - MV_W'(SR_SIDE / 2);
    assign mv_y    = MV_W'(cand_idx[IDX_W-1:HALF_W]) - MV_W'(SR_SIDE / 2);
    assign mv_pack = {mv_y, mv_x};

    for (genvar p = 0; p < NPART; p++) begin : g_cell
        vbs_min_cell #(.SAD_W(SAD_W), .MVP_W(MVP_W)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .take     (take),
            .load_all (load_all),
            .sad_in   (part_sad[p*SAD_W +: SAD_W]),
            .mv_in    (mv_pack),
            .best_sad (best_sad[p*SAD_W +: SAD_W]),
            .best_mv  (best_mv[p*MVP_W +: MVP_W])
        );
    end
endmodule

// File: rtl/vbs_sad_merge_chk.sv
// Module: vbs_sad_merge_chk
// Property checker bound to vbs_sad_merge. It watches only the top ports.
module vbs_sad_merge_chk
    import vbs_pkg::*;
#(
    parameter int SUB_W = 12,
    parameter int SAD_W = 16,
    parameter int MV_W  = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cand_valid,
    input logic                    mb_start,
    input logic [NSUB*SUB_W-1:0]   sub_sad,
    input logic [NPART*SAD_W-1:0]  best_sad,
    input logic [NPART*2*MV_W-1:0] best_mv,
    input logic                    done
);
    logic [SAD_W+1:0] quad_sum;
    assign quad_sum = (SAD_W+2)'(best_sad[(OFS_8X8  )*SAD_W +: SAD_W])
                    + (SAD_W+2)'(best_sad[(OFS_8X8+1)*SAD_W +: SAD_W])
                    + (SAD_W+2)'(best_sad[(OFS_8X8+2)*SAD_W +: SAD_W])
                    + (SAD_W+2)'(best_sad[(OFS_8X8+3)*SAD_W +: SAD_W]);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(cand_valid));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cand_valid) |-> ($stable(best_sad) && $stable(best_mv)));

    // The whole-block minimum can never be below the sum of the quadrant minima (R4).
    p_full_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (SAD_W+2)'(best_sad[OFS_FULL*SAD_W +: SAD_W]) >= quad_sum);

    for (genvar q = 0; q < N_8X8; q++) begin : g_qchk
        localparam int A = OFS_8X4 + 4*(q/2) + (q%2);
        p_quad_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (SAD_W+1)'(best_sad[(OFS_8X8+q)*SAD_W +: SAD_W]) >=
            (SAD_W+1)'(best_sad[A*SAD_W +: SAD_W]) + (SAD_W+1)'(best_sad[(A+2)*SAD_W +: SAD_W]));
    end

    for (genvar p = 0; p < NPART; p++) begin : g_mono
        p_min_monotone_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(cand_valid && mb_start) |->
            (best_sad[p*SAD_W +: SAD_W] <= $past(best_sad[p*SAD_W +: SAD_W])));
    end

    // Sub-block inputs are consumed combinationally; keep them visibly referenced.
    logic unused_ok;
    assign unused_ok = ^sub_sad;
endmodule

bind vbs_sad_merge vbs_sad_merge_chk #(.SUB_W(SUB_W), .SAD_W(SAD_W), .MV_W(MV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cand_valid (cand_valid),
    .mb_start   (mb_start),
    .sub_sad    (sub_sad),
    .best_sad   (best_sad),
    .best_mv    (best_mv),
    .done       (done)
);

// File: tb/vbs_sad_merge_test.sv
// Directed bench with a behavioural model of per-partition minimum tracking.
module vbs_sad_merge_test;
    localparam int SUB_W = 12, SAD_W = 16, MV_W = 5, SR_SIDE = 16;
    localparam int NP = 41, NC = 256;

    logic clk = 1'b0, rst_n = 1'b0, cand_valid = 1'b0, mb_start = 1'b0;
    logic [16*SUB_W-1:0]  sub_sad = '0;
    logic [NP*SAD_W-1:0]  best_sad;
    logic [NP*2*MV_W-1:0] best_mv;
    logic done;

    int n_chk = 0, n_bad = 0;
    int unsigned cur [16];
    int unsigned m_sad [NP];
    int m_x [NP], m_y [NP];
    int m_cnt = 0;
    bit m_act = 0, exp_done = 0;

    vbs_sad_merge #(.SUB_W(SUB_W), .SAD_W(SAD_W), .MV_W(MV_W), .SR_SIDE(SR_SIDE)) uut (
        .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .mb_start(mb_start),
        .sub_sad(sub_sad), .best_sad(best_sad), .best_mv(best_mv), .done(done)
    );

    always #5 clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish (actual hung, expected completion)");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    function automatic int unsigned part_sum(int p);
        int r0, c0, h, w;
        int unsigned s = 0;
        if (p < 16)      begin r0 = p/4;            c0 = p%4;            h = 1; w = 1; end
        else if (p < 24) begin r0 = (p-16)/2;       c0 = ((p-16)%2)*2;   h = 1; w = 2; end
        else if (p < 32) begin r0 = ((p-24)/4)*2;   c0 = (p-24)%4;       h = 2; w = 1; end
        else if (p < 36) begin r0 = ((p-32)/2)*2;   c0 = ((p-32)%2)*2;   h = 2; w = 2; end
        else if (p < 38) begin r0 = (p-36)*2;       c0 = 0;              h = 2; w = 4; end
        else if (p < 40) begin r0 = 0;              c0 = (p-38)*2;       h = 4; w = 2; end
        else             begin r0 = 0;              c0 = 0;              h = 4; w = 4; end
        for (int rr = 0; rr < h; rr++)
            for (int cc = 0; cc < w; cc++)
                s += cur[(r0+rr)*4 + c0 + cc];
        return s;
    endfunction

    task automatic check(bit ok, string rq, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Compare all 41 slots with the model; the tag follows the partition group.
    task automatic compare_all(string ctx);
        for (int p = 0; p < NP; p++) begin
            logic signed [MV_W-1:0] gx, gy;
            int gs;
            string rq;
            rq = (p < 16) ? "R2" : (p < 32) ? "R3" : "R4";
            gs = int'(best_sad[p*SAD_W +: SAD_W]);
            gx = best_mv[p*2*MV_W +: MV_W];
            gy = best_mv[p*2*MV_W + MV_W +: MV_W];
            check(gs == int'(m_sad[p]), rq, $sformatf("%s slot %0d sad", ctx, p), gs, int'(m_sad[p]));
            check(int'(gx) == m_x[p] && int'(gy) == m_y[p], "R5",
                  $sformatf("%s slot %0d mv(x*100+y)", ctx, p), int'(gx)*100 + int'(gy), m_x[p]*100 + m_y[p]);
        end
    endtask

    // Present one candidate for one cycle, update the model, check done.
    task automatic step(bit start, string rq);
        @(negedge clk);
        for (int k = 0; k < 16; k++) sub_sad[k*SUB_W +: SUB_W] = SUB_W'(cur[k]);
        cand_valid = 1'b1;
        mb_start   = start;
        if (start) begin m_act = 1; m_cnt = 0; end
        exp_done = 0;
        if (m_act) begin
            for (int p = 0; p < NP; p++) begin
                int unsigned v;
                v = part_sum(p);
                if (start || v < m_sad[p]) begin
                    m_sad[p] = v; m_x[p] = (m_cnt % 16) - 8; m_y[p] = (m_cnt / 16) - 8;
                end
            end
            m_cnt++;
            if (m_cnt == NC) begin m_act = 0; exp_done = 1; end
        end
        @(posedge clk); #1;
        check(done == exp_done, rq, "done level", int'(done), int'(exp_done));
    endtask

    task automatic idle(int n);
        @(negedge clk);
        cand_valid = 1'b0; mb_start = 1'b0;
        for (int i = 1; i < n; i++) @(negedge clk);
    endtask

    task automatic rand_cur();
        for (int k = 0; k < 16; k++) cur[k] = $urandom() & 32'hFFF;
    endtask

    task automatic t_reset();
        for (int p = 0; p < NP; p++) begin m_sad[p] = 0; m_x[p] = 0; m_y[p] = 0; end
        repeat (3) @(posedge clk);
        #1; compare_all("R1 in reset");
        check(done == 1'b0, "R1", "done in reset", int'(done), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        compare_all("R1 after release");
    endtask

    // Full random scan, optionally with idle gaps between candidates.
    task automatic t_scan(bit gaps, string rq);
        for (int n = 0; n < NC; n++) begin
            rand_cur();
            step(n == 0, rq);
            if (gaps && (n % 3 == 1)) idle(2);
        end
        compare_all(rq);
        idle(1);
    endtask

    task automatic t_tie();
        for (int n = 0; n < NC; n++) begin
            for (int k = 0; k < 16; k++) cur[k] = 100;
            step(n == 0, "R6");
        end
        compare_all("R6 equal costs");
        idle(1);
        for (int n = 0; n < NC; n++) begin
            for (int k = 0; k < 16; k++) cur[k] = 4000 - n*10 - k;
            step(n == 0, "R5");
        end
        compare_all("R5 falling costs");
        idle(1);
    endtask

    task automatic t_restart();
        for (int n = 0; n < 100; n++) begin rand_cur(); step(n == 0, "R7"); end
        for (int k = 0; k < 16; k++) cur[k] = 4095;
        step(1, "R7");
        compare_all("R7 restart load");
        for (int n = 1; n < NC; n++) begin rand_cur(); step(0, "R7"); end
        compare_all("R7 after restart");
        idle(1);
    endtask

    task automatic t_hold();
        for (int k = 0; k < 16; k++) cur[k] = 0;
        step(0, "R9");
        step(0, "R9");
        idle(4);
        #1; compare_all("R9 ignored after done");
        check(done == 1'b0, "R9", "done idle", int'(done), 0);
    endtask

    task automatic t_back2back();
        for (int n = 0; n < NC; n++) begin rand_cur(); step(n == 0, "R8"); end
        compare_all("R8 at done");
        rand_cur();
        step(1, "R8");
        compare_all("R8 new block loaded");
        for (int n = 1; n < NC; n++) begin rand_cur(); step(0, "R8"); end
        compare_all("R8 second block");
        idle(1);
    endtask

    initial begin
        t_reset();
        t_scan(1'b0, "R3");
        t_scan(1'b1, "R10");
        t_tie();
        t_restart();
        t_hold();
        t_back2back();
        repeat (3) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule